// File: doc/BRIEF.md
# Clock-Stepped Flip-Flop Ring Oscillator

This block models, one gate delay per clock cycle, a ring of simple set-reset cells. Each cell is built from two gates that inhibit each other. Every gate is an AND-NOT cell: its output is high only if its own enable line is high and none of its inhibiting inputs is high. When enabled, a gate behaves as a NOR of its inhibitors. Both outputs of each cell inhibit the matching gates of the next cell. The connection that closes the ring decides whether it oscillates. With an even stage count it crosses from the top row to the bottom row, and with an odd count it keeps to the same row. Without that closing link the ring would settle into a static pattern.

Each register holds one gate output and is recomputed from all gate outputs of the previous cycle. A modulo-4N phase counter marks where the ring is in its cycle. Start-up is made asymmetric on purpose: only the bottom gate of the last stage is high, which drives the ring out of its balanced state. A global enable stops the ring and holds it dark. Raising the enable again restarts the ring from the start-up state.

Top module: `flipFlopRingOsc`

## Requirements
- R1: A synchronous reset (rst high at a clock edge, with priority over all other inputs) makes gateOut equal to a single high bit at index 2N-1 (4'b1000 for N=2) and sets phase to 0 at that edge.
- R2: Gate 2k is the top gate of stage k and gate 2k+1 is its bottom gate. On each running cycle, top(k) becomes gateEn[2k] AND NOT(bottom(k) OR top(k-1)), and bottom(k) becomes gateEn[2k+1] AND NOT(top(k) OR bottom(k-1)). For stage 0, the previous stage is stage N-1, with its rows swapped when N is even and kept when N is odd.
- R3: For N=2 with all gate enables high, the gateOut sequence from the start-up state is 8,A,2,6,4,5,1,9 (hex), and it repeats every 8 cycles.
- R4: In that free-running mode, exactly one gate output changes on every cycle, and each gate is high for 3 cycles and low for 5 cycles out of 8.
- R5: Within the first cycle after start-up, the outputs rise in the order gate1, gate2, gate0, gate3, at phases 1, 3, 5 and 7, which places them 2 cycles apart.
- R6: phase is 0 in the start-up state and increases by one on each running cycle, wrapping from 4N-1 to 0.
- R7: An edge with en low and rst low forces all of gateOut to 0 and phase to 0. Both stay there for as long as en is low.
- R8: The first edge with en high after a period of en low loads the start-up state with phase 0. The sequence of R3 then continues from the next edge.
- R9: A gate whose gateEn bit is low while the ring is running is 0 after the next edge. The other gates still follow R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge is one gate delay |
| rst | input | 1 | Synchronous reset to the start-up state |
| en | input | 1 | Global enable; low holds all gates dark |
| gateEn | input | 2N | Enable line of each gate |
| gateOut | output | 2N | Gate states; bit 2k is the top gate and bit 2k+1 the bottom gate of stage k |
| phase | output | clog2(4N) | Cycle position since start-up |

## Verification
All gate state lives in the ring registers, and every output feeds the next cycle of the ring. A wrong bit therefore appears at gateOut on the same edge that produces it. Within a few cycles it also breaks the one-change-per-cycle rule or the 3-of-8 high time. A corrupted phase counter disagrees with the gate pattern at once, because each phase value belongs to exactly one pattern. A fault in start-up or re-enable handling shows up on the first edge after the event, as a pattern other than the single high bit at index 2N-1.

// File: rtl/ffRingPkg.sv
package ffRingPkg;
  // Control strobes issued to the ring datapath each cycle
  typedef struct packed {
    logic load;   // load the asymmetric start-up state
    logic clear;  // force every gate low
    logic step;   // advance the ring by one gate delay
  } ringStrobe_t;
endpackage

// File: rtl/ringCtrl.sv
module ringCtrl
  import ffRingPkg::*;
#(
  parameter int N = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  output ringStrobe_t                 strobe,
  output logic [$clog2(4*N)-1:0]      phase
);
  localparam int PW   = $clog2(4*N);
  localparam int LAST = 4*N - 1;

  logic idle;

  always_comb begin
    strobe.load  = rst | (en & idle);
    strobe.clear = ~rst & ~en;
    strobe.step  = ~rst & en & ~idle;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idle  <= 1'b0;
      phase <= '0;
    end else if (!en) begin
      idle  <= 1'b1;
      phase <= '0;
    end else if (idle) begin
      idle  <= 1'b0;
      phase <= '0;
    end else if (phase == PW'(LAST)) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/ringDatapath.sv
module ringDatapath
  import ffRingPkg::*;
#(
  parameter int N = 2
) (
  input  logic               clk,
  input  ringStrobe_t        strobe,
  input  logic [2*N-1:0]     gateEn,
  output logic [2*N-1:0]     gateOut
);
  localparam int G = 2 * N;
  localparam logic [G-1:0] START = {1'b1, {(G-1){1'b0}}};

  logic [G-1:0] gateQ;
  logic [G-1:0] gateNext;

  for (genvar k = 0; k < N; k++) begin : g_stage
    logic prevTop;
    logic prevBot;
    if (k == 0) begin : g_wrap
      if (N % 2 == 0) begin : g_twist
        assign prevTop = gateQ[2*N-1];
        assign prevBot = gateQ[2*N-2];
      end else begin : g_straight
        assign prevTop = gateQ[2*N-2];
        assign prevBot = gateQ[2*N-1];
      end
    end else begin : g_chain
      assign prevTop = gateQ[2*k-2];
      assign prevBot = gateQ[2*k-1];
    end
    assign gateNext[2*k]   = gateEn[2*k]   & ~(gateQ[2*k+1] | prevTop);
    assign gateNext[2*k+1] = gateEn[2*k+1] & ~(gateQ[2*k]   | prevBot);
  end

  always_ff @(posedge clk) begin
    if (strobe.load)       gateQ <= START;
    else if (strobe.clear) gateQ <= '0;
    else if (strobe.step)  gateQ <= gateNext;
  end

  assign gateOut = gateQ;
endmodule

// File: rtl/flipFlopRingOsc.sv
module flipFlopRingOsc
  import ffRingPkg::*;
#(
  parameter int N = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic [2*N-1:0]         gateEn,
  output logic [2*N-1:0]         gateOut,
  output logic [$clog2(4*N)-1:0] phase
);
  ringStrobe_t strobe;

  ringCtrl #(.N(N)) i_ringCtrl (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .strobe(strobe),
    .phase (phase)
  );

  ringDatapath #(.N(N)) i_ringDatapath (
    .clk    (clk),
    .strobe (strobe),
    .gateEn (gateEn),
    .gateOut(gateOut)
  );
endmodule

// File: rtl/ringChecker.sv
module ringChecker #(
  parameter int N = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   en,
  input logic [2*N-1:0]         gateEn,
  input logic [2*N-1:0]         gateOut,
  input logic [$clog2(4*N)-1:0] phase
);
  localparam int G    = 2 * N;
  localparam int PW   = $clog2(4*N);
  localparam int LAST = 4*N - 1;
  localparam logic [G-1:0] START = {1'b1, {(G-1){1'b0}}};

  logic prevRun;   // ring was running (not idle) at the previous edge
  logic cleanRun;  // no gate has been disabled since the last start-up

  always_ff @(posedge clk) begin
    if (rst) begin
      prevRun  <= 1'b1;
      cleanRun <= 1'b1;
    end else begin
      prevRun <= en;
      if (en && !prevRun)              cleanRun <= 1'b1;
      else if (en && !(&gateEn))       cleanRun <= 1'b0;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (gateOut == START && phase == '0));

  a_r7_disabled_dark: assert property (@(posedge clk) disable iff (rst)
    !en |=> (gateOut == '0 && phase == '0));

  a_r9_gate_off: assert property (@(posedge clk) disable iff (rst)
    (en && prevRun) |=> ((gateOut & ~$past(gateEn)) == '0));

  a_r4_one_change: assert property (@(posedge clk) disable iff (rst)
    (en && prevRun && cleanRun && (&gateEn)) |=>
      ($countones(gateOut ^ $past(gateOut)) == 1));

  a_r6_phase_step: assert property (@(posedge clk) disable iff (rst)
    (en && prevRun) |=>
      (phase == (($past(phase) == PW'(LAST)) ? PW'(0) : PW'($past(phase) + 1'b1))));

  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    (en && !prevRun) |=> (gateOut == START && phase == '0));
endmodule

bind flipFlopRingOsc ringChecker #(.N(N)) i_ringChecker (.*);

// File: tb/test_flipFlopRingOsc.sv
module test_flipFlopRingOsc;
  localparam int N  = 2;
  localparam int G  = 2 * N;
  localparam int PW = $clog2(4*N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en  = 1'b1;
  logic [G-1:0]  gateEn = '1;
  logic [G-1:0]  gateOut;
  logic [PW-1:0] phase;

  int checks = 0;
  int errors = 0;

  flipFlopRingOsc #(.N(N)) i_flipFlopRingOsc (
    .clk(clk), .rst(rst), .en(en), .gateEn(gateEn),
    .gateOut(gateOut), .phase(phase)
  );

  always #5 clk = ~clk;

  function automatic int seqAt(int k);
    case (k % 8)
      0: return 'h8;
      1: return 'hA;
      2: return 'h2;
      3: return 'h6;
      4: return 'h4;
      5: return 'h5;
      6: return 'h1;
      default: return 'h9;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    rst = 1'b1; en = 1'b1; gateEn = '1;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    check("R1 reset gates", int'(gateOut), 'h8);
    check("R1 reset phase", int'(phase), 0);
  endtask

  task automatic testSequence();
    int highs[G];
    logic [G-1:0] prev;
    doReset();
    for (int g = 0; g < G; g++) highs[g] = 0;
    prev = gateOut;
    for (int k = 1; k <= 24; k++) begin
      tick();
      check("R3 sequence", int'(gateOut), seqAt(k));
      check("R6 phase", int'(phase), k % 8);
      check("R4 one change", $countones(gateOut ^ prev), 1);
      prev = gateOut;
      if (k > 16)
        for (int g = 0; g < G; g++) highs[g] += int'(gateOut[g]);
    end
    for (int g = 0; g < G; g++) check("R4 high time", highs[g], 3);
  endtask

  task automatic testOnsets();
    int onset[G];
    logic [G-1:0] prev;
    doReset();
    for (int g = 0; g < G; g++) onset[g] = -1;
    prev = gateOut;
    for (int k = 1; k <= 8; k++) begin
      tick();
      for (int g = 0; g < G; g++)
        if (gateOut[g] && !prev[g] && onset[g] < 0) onset[g] = k;
      prev = gateOut;
    end
    check("R5 onset gate1", onset[1], 1);
    check("R5 onset gate2", onset[2], 3);
    check("R5 onset gate0", onset[0], 5);
    check("R5 onset gate3", onset[3], 7);
  endtask

  task automatic testDisable();
    doReset();
    tick(); tick(); tick();
    en = 1'b0;
    tick();
    check("R7 dark gates", int'(gateOut), 0);
    check("R7 dark phase", int'(phase), 0);
    tick(); tick(); tick();
    check("R7 held dark", int'(gateOut), 0);
    en = 1'b1;
    tick();
    check("R8 restart gates", int'(gateOut), 'h8);
    check("R8 restart phase", int'(phase), 0);
    tick();
    check("R8 resume gates", int'(gateOut), 'hA);
    check("R8 resume phase", int'(phase), 1);
  endtask

  task automatic testGateEnable();
    doReset();
    gateEn = 4'b1101;
    tick();
    check("R9 gate1 off", int'(gateOut[1]), 0);
    check("R9 others by rule", int'(gateOut), 'h8);
    gateEn = '1;
    tick();
    check("R2 rule after restore", int'(gateOut), 'hA);
  endtask

  task automatic testMidReset();
    doReset();
    for (int k = 0; k < 5; k++) tick();
    rst = 1'b1;
    tick();
    check("R1 mid-run reset gates", int'(gateOut), 'h8);
    check("R1 mid-run reset phase", int'(phase), 0);
    rst = 1'b0;
  endtask

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testSequence();
    testOnsets();
    testDisable();
    testGateEnable();
    testMidReset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule